// File: doc/BRIEF.md
# Dual Wiper Code Controller

This block keeps two 10-bit wiper codes, channel 0 and channel 1, for a pair of digitally set resistors. It acts on decoded commands that arrive one per strobe. A command can load a code directly, step a code up or down by one position, or double or halve a code (a shift of one bit, close to a 6 dB change). A read command copies one code into a readback register. Codes stop at the ends of the 0 to 1023 range and do not wrap.

An active-low write-protect input blocks every command that would change a code. Reads still work while it is low. A restore request loads both codes from externally supplied stored values in a single cycle. The restore works whatever the write-protect level is, and it wins over a command strobe in the same cycle. After reset both codes sit at midscale.

Each code register is the only state of its channel. A write strobe moves the code register straight from its held value to the new value at the next clock edge, so there is no separate busy or execute state. Every command completes on the clock edge that follows its strobe.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: After reset both wiper codes equal 512 and the readback word equals 0.
- R2: Opcode 1 (write) with address 0 or 1 loads the data field into that channel's code on the clock edge after the strobe.
- R3: Opcode 2 (increment) adds one to the addressed code, and a code of 1023 stays at 1023.
- R4: Opcode 3 (decrement) subtracts one from the addressed code, and a code of 0 stays at 0.
- R5: Opcode 4 (shift left) doubles the addressed code. A code of 512 or more becomes 1023, and a code of 0 becomes 1.
- R6: Opcode 5 (shift right) halves the addressed code and rounds down, so a code of 0 stays at 0.
- R7: Opcode 6 (read) copies the addressed code into the readback word on the next edge. Address 2 or 3 gives 0. A read changes no code and is carried out while write-protect is low.
- R8: While write-protect is low, opcodes 1 to 5 leave both codes unchanged.
- R9: A command whose address is 2 or 3 leaves both codes unchanged.
- R10: A restore request loads both codes from the restore inputs on the next edge, whatever the write-protect level. Any strobe in the same cycle is discarded, and the readback word is left unchanged.
- R11: Opcodes 0 and 7 change neither the codes nor the readback word.
- R12: A code changes only on an edge where a restore or an accepted command addresses that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per high cycle |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | 2 | Channel address |
| cmd_data | input | 10 | Data for the write command |
| wp_n | input | 1 | Active-low write protect |
| restore_req | input | 1 | Load both codes from the restore inputs |
| restore_code0 | input | 10 | Stored code for channel 0 |
| restore_code1 | input | 10 | Stored code for channel 1 |
| wiper0 | output | 10 | Channel 0 code |
| wiper1 | output | 10 | Channel 1 code |
| read_word | output | 10 | Readback register |

## Verification
The bench runs every code from 0 to 1023 through each operation on both channels. It checks the addressed channel against an arithmetic model and checks that the other channel is untouched. This exposes a step that wraps at 1023 or at 0. It also exposes a left shift that drops the top bit instead of saturating, and a left shift of 0 that stays at 0. Further runs repeat commands with write-protect low and with an out-of-range address; a gate missing on either would show up as a moved code. A restore issued together with a write and with write-protect low shows whether the restore loses priority or the strobe leaks into the readback word.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_WRITE = 3'd1,
        OP_INC   = 3'd2,
        OP_DEC   = 3'd3,
        OP_SHL   = 3'd4,
        OP_SHR   = 3'd5,
        OP_READ  = 3'd6,
        OP_RSVD  = 3'd7
    } wiper_op_e;

    function automatic logic op_mutates(input wiper_op_e op);
        return (op == OP_WRITE) || (op == OP_INC) || (op == OP_DEC) ||
               (op == OP_SHL)   || (op == OP_SHR);
    endfunction

endpackage

// File: rtl/wiper_step_calc.sv
module wiper_step_calc
    import wiper_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  wiper_op_e          op,
    input  logic [CODE_W-1:0]  cur,
    input  logic [CODE_W-1:0]  data,
    output logic [CODE_W-1:0]  nxt
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

    always_comb begin
        unique case (op)
            OP_WRITE: nxt = data;
            OP_INC:   nxt = (cur == CODE_MAX) ? CODE_MAX : cur + CODE_ONE;
            OP_DEC:   nxt = (cur == '0) ? '0 : cur - CODE_ONE;
            OP_SHL: begin
                if (cur[CODE_W-1])
                    nxt = CODE_MAX;
                else if (cur == '0)
                    nxt = CODE_ONE;
                else
                    nxt = {cur[CODE_W-2:0], 1'b0};
            end
            OP_SHR:   nxt = {1'b0, cur[CODE_W-1:1]};
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/wiper_channel.sv
module wiper_channel
    import wiper_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               apply,
    input  wiper_op_e          op,
    input  logic [CODE_W-1:0]  data,
    input  logic               restore,
    input  logic [CODE_W-1:0]  restore_val,
    output logic [CODE_W-1:0]  code
);
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic [CODE_W-1:0] step_val;

    wiper_step_calc #(.CODE_W(CODE_W)) u_step (
        .op   (op),
        .cur  (code),
        .data (data),
        .nxt  (step_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            code <= CODE_MID;
        else if (restore)
            code <= restore_val;
        else if (apply)
            code <= step_val;
    end

    // R10: restore lands on the following edge
    assert_restore_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> code == $past(restore_val));

    // R12: code holds when untouched
    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore && !apply) |=> $stable(code));

    // R3: increment at top end saturates
    assert_inc_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore && apply && op == OP_INC && code == CODE_MAX) |=> code == CODE_MAX);

    // R4: decrement at zero saturates
    assert_dec_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore && apply && op == OP_DEC && code == '0) |=> code == '0);

    // R5: left shift of upper half saturates
    assert_shl_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore && apply && op == OP_SHL && code[CODE_W-1]) |=> code == CODE_MAX);
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl
    import wiper_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int ADDR_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [CODE_W-1:0]  cmd_data,
    input  logic               wp_n,
    input  logic               restore_req,
    input  logic [CODE_W-1:0]  restore_code0,
    input  logic [CODE_W-1:0]  restore_code1,
    output logic [CODE_W-1:0]  wiper0,
    output logic [CODE_W-1:0]  wiper1,
    output logic [CODE_W-1:0]  read_word
);
    localparam int NUM_CH = 2;

    wiper_op_e          op;
    logic [CODE_W-1:0]  codes    [NUM_CH];
    logic [CODE_W-1:0]  rest_val [NUM_CH];
    logic               addr_ok;
    logic               cmd_live;

    assign op          = wiper_op_e'(cmd_op);
    assign addr_ok     = (cmd_addr < ADDR_W'(NUM_CH));
    assign cmd_live    = cmd_valid && !restore_req && addr_ok;
    assign rest_val[0] = restore_code0;
    assign rest_val[1] = restore_code1;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic hit;
        assign hit = cmd_live && wp_n && op_mutates(op) && (cmd_addr == ADDR_W'(ch));

        wiper_channel #(.CODE_W(CODE_W)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .apply       (hit),
            .op          (op),
            .data        (cmd_data),
            .restore     (restore_req),
            .restore_val (rest_val[ch]),
            .code        (codes[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            read_word <= '0;
        else if (cmd_valid && !restore_req && op == OP_READ)
            read_word <= addr_ok ? codes[cmd_addr[0]] : '0;
    end

    assign wiper0 = codes[0];
    assign wiper1 = codes[1];

    // R8: write protect freezes both codes
    assert_wp_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && !restore_req) |=> ($stable(wiper0) && $stable(wiper1)));

    // R9: out-of-range address touches nothing
    assert_bad_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !restore_req && !addr_ok) |=> ($stable(wiper0) && $stable(wiper1)));

    // R10: restore discards the strobe for readback
    assert_restore_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |=> $stable(read_word));

    // R7: read leaves codes alone
    assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !restore_req && op == OP_READ) |=> ($stable(wiper0) && $stable(wiper1)));
endmodule

// File: tb/dual_wiper_ctrl_bench.sv
module dual_wiper_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [1:0] cmd_addr = '0;
    logic [9:0] cmd_data = '0;
    logic       wp_n = 1'b1;
    logic       restore_req = 1'b0;
    logic [9:0] restore_code0 = '0;
    logic [9:0] restore_code1 = '0;
    logic [9:0] wiper0, wiper1, read_word;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dual_wiper_ctrl u_dual_wiper_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n),
        .restore_req(restore_req), .restore_code0(restore_code0),
        .restore_code1(restore_code1), .wiper0(wiper0), .wiper1(wiper1),
        .read_word(read_word)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cmd(input int op, input int addr, input int data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = 2'(addr); cmd_data = 10'(data);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic int model(input int op, input int c, input int d);
        case (op)
            1: return d;
            2: return (c + 1 > 1023) ? 1023 : c + 1;
            3: return (c == 0) ? 0 : c - 1;
            4: return (c == 0) ? 1 : ((c * 2 > 1023) ? 1023 : c * 2);
            5: return c / 2;
            default: return c;
        endcase
    endfunction

    function automatic int code_of(input int ch);
        return (ch == 0) ? int'(wiper0) : int'(wiper1);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 wiper0 reset", wiper0, 512);
        chk("R1 wiper1 reset", wiper1, 512);
        chk("R1 read reset", read_word, 0);

        for (int ch = 0; ch < 2; ch++) begin
            for (int c = 0; c < 1024; c++) begin
                for (int op = 2; op <= 5; op++) begin
                    int other;
                    cmd(1, ch, c);
                    chk("R2 write", code_of(ch), c);
                    other = code_of(1 - ch);
                    cmd(op, ch, 0);
                    case (op)
                        2: chk("R3 increment", code_of(ch), model(op, c, 0));
                        3: chk("R4 decrement", code_of(ch), model(op, c, 0));
                        4: chk("R5 shift left", code_of(ch), model(op, c, 0));
                        default: chk("R6 shift right", code_of(ch), model(op, c, 0));
                    endcase
                    chk("R12 other channel", code_of(1 - ch), other);
                end
                cmd(6, ch, 0);
                chk("R7 readback", read_word, code_of(ch));
            end
        end

        cmd(1, 0, 100);
        cmd(1, 1, 900);
        wp_n = 1'b0;
        for (int op = 1; op <= 5; op++) begin
            cmd(op, 0, 7);
            cmd(op, 1, 7);
            chk("R8 wp ch0", wiper0, 100);
            chk("R8 wp ch1", wiper1, 900);
        end
        cmd(6, 1, 0);
        chk("R7 read under wp", read_word, 900);
        wp_n = 1'b1;

        for (int a = 2; a < 4; a++) begin
            for (int op = 1; op <= 5; op++) begin
                cmd(op, a, 3);
                chk("R9 bad addr ch0", wiper0, 100);
                chk("R9 bad addr ch1", wiper1, 900);
            end
            cmd(6, a, 0);
            chk("R7 read bad addr", read_word, 0);
        end

        cmd(6, 0, 0);
        cmd(0, 0, 5);
        cmd(7, 1, 5);
        chk("R11 nop ch0", wiper0, 100);
        chk("R11 nop ch1", wiper1, 900);
        chk("R11 nop read", read_word, 100);

        wp_n = 1'b0;
        @(negedge clk);
        restore_req = 1'b1; restore_code0 = 10'd33; restore_code1 = 10'd1000;
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_addr = 2'd0; cmd_data = 10'd5;
        @(negedge clk);
        restore_req = 1'b0; cmd_valid = 1'b0;
        chk("R10 restore ch0", wiper0, 33);
        chk("R10 restore ch1", wiper1, 1000);
        @(negedge clk);
        restore_req = 1'b1; restore_code0 = 10'd1; restore_code1 = 10'd2;
        cmd_valid = 1'b1; cmd_op = 3'd6; cmd_addr = 2'd1;
        @(negedge clk);
        restore_req = 1'b0; cmd_valid = 1'b0;
        chk("R10 restore ch0 again", wiper0, 1);
        chk("R10 restore ch1 again", wiper1, 2);
        chk("R10 read discarded", read_word, 100);
        wp_n = 1'b1;

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule